// File: doc/BRIEF.md
# Tri-Speed Transmit Clock-Enable Adapter

This block connects an 8-bit client transmit stream to a physical transmit bus. Both sides run on one clock, which is the physical-side clock. The client never gets a clock of its own. Instead the block produces a client clock enable, and the client advances only on clock edges where that enable is high.

The speed-select input chooses between two modes:

- **Byte mode (1 Gb/s).** The enable stays high. Each client byte appears on the 8-bit physical bus one clock later.
- **Nibble mode (100/10 Mb/s).** The enable is high on every other clock. Each accepted byte goes out as two 4-bit nibbles on consecutive clocks, low nibble first. The transmit-enable and transmit-error flags stay steady across both nibbles.

A change of speed restarts the enable phase and the nibble phase, so the first clock in the new mode always accepts a byte.

Top module: `tx_rate_adapter`

## Requirements
- R1: While `rst_n` is low, at each clock edge `phy_data` is cleared to zero and `phy_en` and `phy_err` are cleared low. In the first cycle after reset is released, `cl_ce` is high.
- R2: While `speed_gig` is 1 (byte mode), `cl_ce` is high in every cycle.
- R3: In byte mode, `phy_data`, `phy_en` and `phy_err` equal the `cl_data`, `cl_valid` and `cl_err` values of the previous cycle.
- R4: While `speed_gig` is 0 (nibble mode), `cl_ce` alternates: high, then low on the next cycle, then high again.
- R5: In nibble mode, a byte taken in a cycle with `cl_ce` high is sent in two steps. On the next cycle `phy_data` carries bits 3:0 of the byte in its bits 3:0, with bits 7:4 zero. On the cycle after that it carries bits 7:4 of the byte in the same position, again with bits 7:4 zero.
- R6: In nibble mode, `phy_en` and `phy_err` equal the `cl_valid` and `cl_err` values that were taken with the byte. They hold for both nibble cycles.
- R7: Client data and flags presented in a cycle where `cl_ce` is low have no effect on the physical outputs.
- R8: In any cycle where `speed_gig` differs from its previous value, `cl_ce` is high. A nibble-mode byte whose second nibble has not yet been sent is dropped at that point, and the byte taken in the switch cycle is sent next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared physical-side clock |
| rst_n | input | 1 | Synchronous reset, active low |
| speed_gig | input | 1 | 1 selects byte mode; 0 selects nibble mode |
| cl_data | input | 8 | Client transmit byte |
| cl_valid | input | 1 | Client data-valid flag |
| cl_err | input | 1 | Client error flag |
| cl_ce | output | 1 | Client clock enable |
| phy_data | output | 8 | Physical transmit data (nibble mode uses bits 3:0 only) |
| phy_en | output | 1 | Physical transmit enable |
| phy_err | output | 1 | Physical transmit error |

## Verification
The hardest case to reach is a speed change that lands between the two nibbles of a byte. At that point the held upper nibble must be dropped, and the enable must come up at once.

The stimulus reaches it directly:

1. Present a byte in nibble mode.
2. Flip the speed select on the very next falling edge, while the second nibble is still pending.
3. Check that the byte driven in that switch cycle appears unchanged one clock later.

The reverse switch is then checked the same way. Separately, every byte value from 0 to 255 is swept through both modes. During each low-enable cycle the client inputs are overwritten with their complements, which shows that they are ignored.

// File: rtl/txra_pkg.sv
package txra_pkg;

  typedef enum logic {
    MODE_NIBBLE = 1'b0,
    MODE_BYTE   = 1'b1
  } rate_mode_e;

  typedef struct packed {
    logic valid;
    logic err;
  } tx_flags_t;

endpackage

// File: rtl/txra_ce_gen.sv
module txra_ce_gen
  import txra_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  rate_mode_e mode,
  output logic       ce,
  output logic       second_nib
);

  logic phase_q;
  logic phase_d;

  // phase_q is 0 on cycles that accept a byte; held 0 in byte mode so that
  // entering nibble mode always starts on an accepting cycle
  always_comb begin
    if (mode == MODE_BYTE) phase_d = 1'b0;
    else                   phase_d = ~phase_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= phase_d;
  end

  assign ce         = (mode == MODE_BYTE) | ~phase_q;
  assign second_nib = (mode == MODE_NIBBLE) & phase_q;

endmodule

// File: rtl/txra_nibble_hold.sv
module txra_nibble_hold #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned NIB_W = DATA_W / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [DATA_W-1:0] byte_in,
  output logic [NIB_W-1:0]  upper_q
);

  function automatic logic [NIB_W-1:0] upper_half(input logic [DATA_W-1:0] b);
    return b[DATA_W-1:NIB_W];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)    upper_q <= '0;
    else if (take) upper_q <= upper_half(byte_in);
  end

endmodule

// File: rtl/txra_out_stage.sv
module txra_out_stage
  import txra_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned NIB_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rate_mode_e        mode,
  input  logic              take,
  input  logic              second_nib,
  input  logic [DATA_W-1:0] byte_in,
  input  tx_flags_t         flags_in,
  input  logic [NIB_W-1:0]  upper_held,
  output logic [DATA_W-1:0] data_q,
  output tx_flags_t         flags_q
);

  function automatic logic [DATA_W-1:0] widen(input logic [NIB_W-1:0] n);
    return {{(DATA_W-NIB_W){1'b0}}, n};
  endfunction

  function automatic logic [NIB_W-1:0] lower_half(input logic [DATA_W-1:0] b);
    return b[NIB_W-1:0];
  endfunction

  logic [DATA_W-1:0] data_d;
  tx_flags_t         flags_d;

  always_comb begin
    data_d  = data_q;
    flags_d = flags_q;
    if (take) begin
      flags_d = flags_in;
      if (mode == MODE_BYTE) data_d = byte_in;
      else                   data_d = widen(lower_half(byte_in));
    end else if (second_nib) begin
      data_d = widen(upper_held);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q  <= '0;
      flags_q <= '0;
    end else begin
      data_q  <= data_d;
      flags_q <= flags_d;
    end
  end

endmodule

// File: rtl/tx_rate_adapter.sv
module tx_rate_adapter
  import txra_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned NIB_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              speed_gig,
  input  logic [DATA_W-1:0] cl_data,
  input  logic              cl_valid,
  input  logic              cl_err,
  output logic              cl_ce,
  output logic [DATA_W-1:0] phy_data,
  output logic              phy_en,
  output logic              phy_err
);

  rate_mode_e       mode;
  logic             take;
  logic             second_nib;
  logic [NIB_W-1:0] upper_held;
  tx_flags_t        flags_in;
  tx_flags_t        flags_q;

  assign mode     = rate_mode_e'(speed_gig);
  assign flags_in = '{valid: cl_valid, err: cl_err};

  txra_ce_gen u_ce (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .ce         (take),
    .second_nib (second_nib)
  );

  txra_nibble_hold #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .byte_in (cl_data),
    .upper_q (upper_held)
  );

  txra_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .take       (take),
    .second_nib (second_nib),
    .byte_in    (cl_data),
    .flags_in   (flags_in),
    .upper_held (upper_held),
    .data_q     (phy_data),
    .flags_q    (flags_q)
  );

  assign cl_ce   = take;
  assign phy_en  = flags_q.valid;
  assign phy_err = flags_q.err;

endmodule

// File: rtl/tx_rate_adapter_chk.sv
module tx_rate_adapter_chk #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned NIB_W = DATA_W / 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              speed_gig,
  input logic [DATA_W-1:0] cl_data,
  input logic              cl_valid,
  input logic              cl_err,
  input logic              cl_ce,
  input logic [DATA_W-1:0] phy_data,
  input logic              phy_en,
  input logic              phy_err,
  input logic              second_nib
);

  localparam logic [DATA_W-NIB_W-1:0] ZHI = '0;

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (phy_data == '0 && !phy_en && !phy_err));

  p_gig_ce_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    speed_gig |-> cl_ce);

  p_gig_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    speed_gig |=> (phy_data == $past(cl_data) && phy_en == $past(cl_valid)
                   && phy_err == $past(cl_err)));

  p_nib_ce_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!speed_gig && cl_ce) |=> (speed_gig || !cl_ce));

  p_nib_ce_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!speed_gig && !cl_ce) |=> cl_ce);

  p_nib_low_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!speed_gig && cl_ce) |=> (phy_data == {ZHI, $past(cl_data[NIB_W-1:0])}));

  p_nib_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!speed_gig && cl_ce) |=> (phy_en == $past(cl_valid) && phy_err == $past(cl_err)));

  p_nib_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    second_nib |=> (phy_en == $past(phy_en) && phy_err == $past(phy_err)
                    && phy_data[DATA_W-1:NIB_W] == ZHI));

  p_switch_ce_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (speed_gig != $past(speed_gig)) |-> cl_ce);

endmodule

bind tx_rate_adapter tx_rate_adapter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .speed_gig  (speed_gig),
  .cl_data    (cl_data),
  .cl_valid   (cl_valid),
  .cl_err     (cl_err),
  .cl_ce      (cl_ce),
  .phy_data   (phy_data),
  .phy_en     (phy_en),
  .phy_err    (phy_err),
  .second_nib (second_nib)
);

// File: tb/tx_rate_adapter_test.sv
module tx_rate_adapter_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       speed_gig = 1'b0;
  logic [7:0] cl_data = '0;
  logic       cl_valid = 1'b0;
  logic       cl_err = 1'b0;
  logic       cl_ce;
  logic [7:0] phy_data;
  logic       phy_en;
  logic       phy_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tx_rate_adapter uut (
    .clk(clk), .rst_n(rst_n), .speed_gig(speed_gig),
    .cl_data(cl_data), .cl_valid(cl_valid), .cl_err(cl_err),
    .cl_ce(cl_ce), .phy_data(phy_data), .phy_en(phy_en), .phy_err(phy_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input int b, input bit v, input bit e);
    cl_data  = 8'(b);
    cl_valid = v;
    cl_err   = e;
  endtask

  // called just after a falling edge where cl_ce is expected high
  task automatic nib_byte(input int b, input bit v, input bit e);
    chk(cl_ce === 1'b1, "R4 ce high on accept", int'(cl_ce), 1);
    drive(b, v, e);
    @(negedge clk); #1;
    chk(phy_data === 8'(b % 16), "R5 low nibble", int'(phy_data), b % 16);
    chk(phy_en === v && phy_err === e, "R6 flags first nibble",
        int'({phy_en, phy_err}), int'({v, e}));
    chk(cl_ce === 1'b0, "R4 ce low", int'(cl_ce), 0);
    drive(255 - b, !v, !e);  // R7: must be ignored
    @(negedge clk); #1;
    chk(phy_data === 8'(b / 16), "R5 high nibble / R7 ignored", int'(phy_data), b / 16);
    chk(phy_en === v && phy_err === e, "R6 flags second nibble / R7",
        int'({phy_en, phy_err}), int'({v, e}));
  endtask

  task automatic gig_byte(input int b, input bit v, input bit e);
    chk(cl_ce === 1'b1, "R2 ce high", int'(cl_ce), 1);
    drive(b, v, e);
    @(negedge clk); #1;
    chk(phy_data === 8'(b) && phy_en === v && phy_err === e, "R3 byte pass",
        int'({phy_en, phy_err, phy_data}), int'({v, e, 8'(b)}));
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    drive(8'hFF, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    #1;
    chk(phy_data === 8'h00 && !phy_en && !phy_err, "R1 idle in reset",
        int'({phy_en, phy_err, phy_data}), 0);
    rst_n = 1'b1;
    #1;
    chk(cl_ce === 1'b1, "R1 first enable after release", int'(cl_ce), 1);

    // nibble-mode sweep
    for (int b = 0; b < 256; b++) nib_byte(b, (b % 3) != 0, (b % 7) == 0);

    // switch to byte mode on an accepting cycle
    speed_gig = 1'b1; #1;
    chk(cl_ce === 1'b1, "R8 ce on switch to byte", int'(cl_ce), 1);
    for (int b = 0; b < 256; b++) gig_byte(b, (b % 5) != 0, (b % 11) == 3);

    // back to nibble mode
    speed_gig = 1'b0; #1;
    chk(cl_ce === 1'b1, "R8 ce on switch to nibble", int'(cl_ce), 1);
    nib_byte(8'h96, 1'b1, 1'b0);

    // switch mid-byte: second nibble pending
    drive(8'hA5, 1'b1, 1'b1);
    @(negedge clk); #1;
    chk(phy_data === 8'h05, "R5 low nibble before switch", int'(phy_data), 5);
    speed_gig = 1'b1; #1;
    chk(cl_ce === 1'b1, "R8 ce on mid-byte switch", int'(cl_ce), 1);
    drive(8'h3C, 1'b1, 1'b0);
    @(negedge clk); #1;
    chk(phy_data === 8'h3C && phy_en && !phy_err, "R8 pending nibble dropped",
        int'(phy_data), 8'h3C);
    gig_byte(8'hC3, 1'b0, 1'b1);

    // reset during operation
    rst_n = 1'b0;
    @(negedge clk); #1;
    chk(phy_data === 8'h00 && !phy_en && !phy_err, "R1 idle after reset",
        int'({phy_en, phy_err, phy_data}), 0);
    rst_n = 1'b1;
    speed_gig = 1'b0; #1;
    chk(cl_ce === 1'b1, "R1 enable after second release", int'(cl_ce), 1);
    nib_byte(8'h5A, 1'b1, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule